// File: doc/BRIEF.md
# Buck Converter Startup and Fault Sequencer

This block is the digital supervisor of a fixed-frequency synchronous step-down converter. It receives comparator decisions that have already been synchronized to its clock: supply above the lockout release level, supply above the lockout entry level, feedback under its undervoltage level, the shutdown request, and the low-side overcurrent comparator qualified by the low-side conduction flag. A one-clock pulse per switching period serves as the time base. From these inputs it produces a gate-drive enable, a reference code that climbs digitally from zero to its regulation value, and an encoded state.

After supply lockout releases and no shutdown is requested, the block enables the drivers and ramps the reference over a set number of switching periods. It then holds the reference at full scale. Feedback undervoltage in regulation turns the drivers off for a timed pause and then repeats the ramp. An overcurrent seen while the low side conducts turns the converter off and keeps it off. Only a shutdown request or a fresh supply lockout clears that condition. All delays are counted in switching periods.

Top module: `buck_seq_ctrl`

## Requirements
- R1: `uvlo_active` is 1 out of reset. It goes to 1 one clock after `vcc_ok_fall` is low. It goes to 0 one clock after `vcc_ok_rise` is high with `vcc_ok_fall` high. With `vcc_ok_fall` high and `vcc_ok_rise` low it keeps its value.
- R2: While `uvlo_active` or `shdn_req` is high, the next state is RESET, and in RESET `drv_en` and `ss_code` are 0. One clock after both are low, RESET moves to SOFTSTART with `ss_code` 0.
- R3: In SOFTSTART, after k cycle pulses (k < SS_CYCLES), `ss_code` equals floor(REF_FINAL*k/SS_CYCLES). The pulse numbered SS_CYCLES moves the block to RUN, where `ss_code` equals REF_FINAL.
- R4: `drv_en` is 1 exactly when the state is SOFTSTART or RUN.
- R5: `fb_under` high in RUN moves the block to HICCUP_WAIT on the next clock, with `drv_en` and `ss_code` at 0. The HICCUP_CYCLES-th cycle pulse in that state returns the block to SOFTSTART with the ramp restarted from 0.
- R6: `fb_under` has no effect in SOFTSTART. The ramp keeps going, and the state changes only as R3 describes.
- R7: `ocp_trip` and `ls_on` both high in SOFTSTART or RUN move the block to LATCHED_OFF on the next clock. `ocp_trip` with `ls_on` low has no effect. In LATCHED_OFF, `drv_en` is 0 and `ocp_latched` is 1.
- R8: LATCHED_OFF is left only through R2 (lockout or shutdown request). Cycle pulses, feedback and overcurrent inputs do not release it.
- R9: `state_code` encodes RESET=0, SOFTSTART=1, RUN=2, HICCUP_WAIT=3, LATCHED_OFF=4. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_tick | input | 1 | One-clock pulse per switching period |
| vcc_ok_rise | input | 1 | Supply above lockout release level |
| vcc_ok_fall | input | 1 | Supply above lockout entry level |
| fb_under | input | 1 | Feedback below undervoltage level |
| shdn_req | input | 1 | Compensation node pulled to shutdown level |
| ocp_trip | input | 1 | Low-side overcurrent comparator |
| ls_on | input | 1 | Low-side switch conducting |
| drv_en | output | 1 | Gate-driver enable |
| ss_code | output | CODE_W | Soft-start reference code |
| state_code | output | 3 | Encoded controller state |
| uvlo_active | output | 1 | Supply lockout in force |
| ocp_latched | output | 1 | Overcurrent shutdown held |

## Verification
The bench walks every step of the ramp and compares each code with the floored formula, using a period count that does not divide REF_FINAL. An off-by-one in the divide or in the end count would then show up as a wrong code or an early RUN. It counts hiccup pulses one at a time. A timer that expired one pulse early or late would restart the ramp at the wrong pulse. It raises feedback undervoltage during the ramp and raises overcurrent with the low side off. A design that reacted to either would enter HICCUP_WAIT or LATCHED_OFF. It drops only the release-level flag while latched. A lockout without hysteresis would then clear the latch, which the bench would see.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_SOFT   = 3'd1,
    ST_RUN    = 3'd2,
    ST_HICCUP = 3'd3,
    ST_LATCH  = 3'd4
  } bsq_state_e;
endpackage

// File: rtl/bsq_uvlo.sv
// Supply lockout with hysteresis built from two threshold flags.
module bsq_uvlo (
  input  logic clk,
  input  logic rst_n,
  input  logic above_rise,
  input  logic above_fall,
  output logic locked
);
  logic lock_q, lock_d;

  always_comb begin
    lock_d = lock_q;
    if (!above_fall)     lock_d = 1'b1;
    else if (above_rise) lock_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b1;
    else        lock_q <= lock_d;
  end

  assign locked = lock_q;
endmodule

// File: rtl/bsq_cycle_timer.sv
// Counts enabled pulses; expire marks the LIMIT-th pulse.
module bsq_cycle_timer #(
  parameter int LIMIT = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic expire
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = step && !clr && (cnt_q == LAST);
endmodule

// File: rtl/bsq_ramp.sv
// Soft-start counter and reference code generator.
module bsq_ramp #(
  parameter int SS_CYCLES = 2048,
  parameter int CODE_W    = 10,
  parameter int REF_FINAL = 800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic              done,
  output logic [CODE_W-1:0] code
);
  localparam int SW = $clog2(SS_CYCLES + 1);
  localparam int PW = CODE_W + SW;
  localparam logic [SW-1:0] LAST = SW'(SS_CYCLES - 1);
  localparam logic [PW-1:0] FIN  = PW'(REF_FINAL);
  localparam bit POW2 = ((SS_CYCLES & (SS_CYCLES - 1)) == 0);

  logic [SW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] prod;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = step && !clr && (cnt_q == LAST);
  assign prod = FIN * PW'(cnt_q);

  generate
    if (POW2) begin : g_shift
      assign code = CODE_W'(prod >> $clog2(SS_CYCLES));
    end else begin : g_div
      assign code = CODE_W'(prod / PW'(SS_CYCLES));
    end
  endgenerate
endmodule

// File: rtl/buck_seq_ctrl.sv
module buck_seq_ctrl #(
  parameter int SS_CYCLES     = 2048,
  parameter int HICCUP_CYCLES = 2048,
  parameter int CODE_W        = 10,
  parameter int REF_FINAL     = 800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_tick,
  input  logic              vcc_ok_rise,
  input  logic              vcc_ok_fall,
  input  logic              fb_under,
  input  logic              shdn_req,
  input  logic              ocp_trip,
  input  logic              ls_on,
  output logic              drv_en,
  output logic [CODE_W-1:0] ss_code,
  output logic [2:0]        state_code,
  output logic              uvlo_active,
  output logic              ocp_latched
);
  import bsq_pkg::*;

  localparam logic [CODE_W-1:0] FULL = CODE_W'(REF_FINAL);

  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       lock, ramp_done, hic_done, ocp_hit;
  logic       ramp_clr, hic_clr;
  logic [CODE_W-1:0] ramp_code;
  bsq_state_e st_q, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  bsq_uvlo u_uvlo (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .above_rise (vcc_ok_rise),
    .above_fall (vcc_ok_fall),
    .locked     (lock)
  );

  assign ramp_clr = (st_q != ST_SOFT);
  assign hic_clr  = (st_q != ST_HICCUP);

  bsq_ramp #(
    .SS_CYCLES (SS_CYCLES),
    .CODE_W    (CODE_W),
    .REF_FINAL (REF_FINAL)
  ) u_ramp (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (ramp_clr),
    .step  (cyc_tick),
    .done  (ramp_done),
    .code  (ramp_code)
  );

  bsq_cycle_timer #(
    .LIMIT (HICCUP_CYCLES)
  ) u_hic (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (hic_clr),
    .step   (cyc_tick),
    .expire (hic_done)
  );

  assign ocp_hit = ocp_trip && ls_on;

  always_comb begin
    st_d = st_q;
    if (lock || shdn_req) begin
      st_d = ST_RESET;
    end else begin
      case (st_q)
        ST_RESET:  st_d = ST_SOFT;
        ST_SOFT: begin
          if (ocp_hit)        st_d = ST_LATCH;
          else if (ramp_done) st_d = ST_RUN;
        end
        ST_RUN: begin
          if (ocp_hit)       st_d = ST_LATCH;
          else if (fb_under) st_d = ST_HICCUP;
        end
        ST_HICCUP: if (hic_done) st_d = ST_SOFT;
        ST_LATCH:  st_d = ST_LATCH;
        default:   st_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) st_q <= ST_RESET;
    else            st_q <= st_d;
  end

  always_comb begin
    case (st_q)
      ST_SOFT: ss_code = ramp_code;
      ST_RUN:  ss_code = FULL;
      default: ss_code = '0;
    endcase
  end

  assign drv_en      = (st_q == ST_SOFT) || (st_q == ST_RUN);
  assign state_code  = st_q;
  assign uvlo_active = lock;
  assign ocp_latched = (st_q == ST_LATCH);
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int CODE_W    = 10,
  parameter int REF_FINAL = 800
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vcc_ok_fall,
  input logic              fb_under,
  input logic              shdn_req,
  input logic              ocp_trip,
  input logic              ls_on,
  input logic              drv_en,
  input logic [CODE_W-1:0] ss_code,
  input logic [2:0]        state_code,
  input logic              uvlo_active,
  input logic              ocp_latched
);
  p_hold_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo_active || shdn_req) |=> (state_code == 3'd0));

  p_reset_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd0) |-> (!drv_en && ss_code == '0));

  p_fall_locks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_ok_fall |=> uvlo_active);

  p_ramp_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd1 && $past(state_code) == 3'd1) |-> (ss_code >= $past(ss_code)));

  p_run_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd2) |-> (ss_code == CODE_W'(REF_FINAL)));

  p_hiccup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd2 && fb_under && !(ocp_trip && ls_on) && !uvlo_active && !shdn_req)
    |=> (state_code == 3'd3 && !drv_en));

  p_ocp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_code == 3'd1 || state_code == 3'd2) && ocp_trip && ls_on && !uvlo_active && !shdn_req)
    |=> ocp_latched);

  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd4 && !uvlo_active && !shdn_req) |=> (state_code == 3'd4));

  p_encoding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state_code <= 3'd4);
endmodule

bind buck_seq_ctrl bsq_checker #(
  .CODE_W    (CODE_W),
  .REF_FINAL (REF_FINAL)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vcc_ok_fall (vcc_ok_fall),
  .fb_under    (fb_under),
  .shdn_req    (shdn_req),
  .ocp_trip    (ocp_trip),
  .ls_on       (ls_on),
  .drv_en      (drv_en),
  .ss_code     (ss_code),
  .state_code  (state_code),
  .uvlo_active (uvlo_active),
  .ocp_latched (ocp_latched)
);

// File: tb/sim_buck_seq_ctrl.sv
`timescale 1ns/1ps
module sim_buck_seq_ctrl;
  localparam int SS   = 12;
  localparam int HIC  = 10;
  localparam int CW   = 10;
  localparam int FIN  = 800;

  logic clk = 1'b0;
  logic rst_n, cyc_tick, vcc_ok_rise, vcc_ok_fall, fb_under, shdn_req, ocp_trip, ls_on;
  logic drv_en, uvlo_active, ocp_latched;
  logic [CW-1:0] ss_code;
  logic [2:0] state_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  buck_seq_ctrl #(
    .SS_CYCLES (SS), .HICCUP_CYCLES (HIC), .CODE_W (CW), .REF_FINAL (FIN)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .cyc_tick (cyc_tick),
    .vcc_ok_rise (vcc_ok_rise), .vcc_ok_fall (vcc_ok_fall),
    .fb_under (fb_under), .shdn_req (shdn_req),
    .ocp_trip (ocp_trip), .ls_on (ls_on),
    .drv_en (drv_en), .ss_code (ss_code), .state_code (state_code),
    .uvlo_active (uvlo_active), .ocp_latched (ocp_latched)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) cyc_tick = 1'b1;
    @(negedge clk) cyc_tick = 1'b0;
  endtask

  // Full ramp from SOFTSTART with code checks at each pulse (R3, R4)
  task automatic ramp_all(input string tag);
    for (int k = 1; k <= SS; k++) begin
      tick();
      if (k < SS) begin
        chk(state_code, 1, {tag, " R3 state"});
        chk(ss_code, (FIN * k) / SS, {tag, " R3 code"});
      end else begin
        chk(state_code, 2, {tag, " R3 run"});
        chk(ss_code, FIN, {tag, " R3 full"});
        chk(drv_en, 1, {tag, " R4 drv run"});
      end
    end
  endtask

  initial begin
    step(200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cyc_tick = 1'b0; vcc_ok_rise = 1'b0; vcc_ok_fall = 1'b0;
    fb_under = 1'b0; shdn_req = 1'b0; ocp_trip = 1'b0; ls_on = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
    chk(uvlo_active, 1, "R1 reset lock");
    chk(state_code, 0, "R2 reset state");
    chk(drv_en, 0, "R2 reset drv");
    chk(ss_code, 0, "R2 reset code");

    // Hysteresis: entry-level flag alone does not release lockout
    vcc_ok_fall = 1'b1;
    step(3);
    chk(uvlo_active, 1, "R1 fall only");
    chk(state_code, 0, "R2 still reset");

    vcc_ok_rise = 1'b1;
    step(1);
    chk(uvlo_active, 0, "R1 release");
    step(1);
    chk(state_code, 1, "R2 enter soft");
    chk(ss_code, 0, "R2 soft code0");
    chk(drv_en, 1, "R4 drv soft");

    // Ramp with feedback undervoltage asserted during first half (R6)
    fb_under = 1'b1;
    for (int k = 1; k <= SS; k++) begin
      if (k == SS / 2) fb_under = 1'b0;
      tick();
      if (k < SS) begin
        chk(state_code, 1, "R6 soft ignores fb");
        chk(ss_code, (FIN * k) / SS, "R3 code");
      end else begin
        chk(state_code, 2, "R3 run");
        chk(ss_code, FIN, "R3 full");
      end
    end
    step(5);
    chk(state_code, 2, "R4 run steady");
    chk(drv_en, 1, "R4 run drv");

    // Hiccup
    fb_under = 1'b1;
    step(1);
    chk(state_code, 3, "R5 hiccup enter");
    chk(drv_en, 0, "R5 hiccup drv");
    chk(ss_code, 0, "R5 hiccup code");
    fb_under = 1'b0;
    for (int k = 1; k < HIC; k++) begin
      tick();
      chk(state_code, 3, "R5 hiccup wait");
    end
    tick();
    chk(state_code, 1, "R5 hiccup restart");
    chk(ss_code, 0, "R5 restart code");
    ramp_all("second");

    // Overcurrent without low-side conduction is ignored
    ocp_trip = 1'b1;
    step(3);
    chk(state_code, 2, "R7 ocp needs ls_on");
    ls_on = 1'b1;
    step(1);
    chk(state_code, 4, "R7 latch run");
    chk(drv_en, 0, "R7 latch drv");
    chk(ocp_latched, 1, "R7 latched flag");
    ocp_trip = 1'b0; ls_on = 1'b0;
    for (int k = 0; k < 20; k++) tick();
    fb_under = 1'b1; step(2); fb_under = 1'b0;
    chk(state_code, 4, "R8 latch holds");

    // Shutdown request clears latch
    shdn_req = 1'b1;
    step(1);
    chk(state_code, 0, "R8 shdn reset");
    tick();
    chk(state_code, 0, "R2 shdn held");
    chk(drv_en, 0, "R2 shdn drv");
    shdn_req = 1'b0;
    step(1);
    chk(state_code, 1, "R8 restart after shdn");
    chk(ocp_latched, 0, "R8 flag cleared");

    // Overcurrent during soft start
    tick(); tick(); tick();
    chk(ss_code, (FIN * 3) / SS, "R3 code k3");
    ocp_trip = 1'b1; ls_on = 1'b1;
    step(1);
    chk(state_code, 4, "R7 latch soft");
    ocp_trip = 1'b0; ls_on = 1'b0;

    // Release-level drop alone does not relock (hysteresis), latch stays
    vcc_ok_rise = 1'b0;
    step(3);
    chk(uvlo_active, 0, "R1 hysteresis hold");
    chk(state_code, 4, "R8 latch no relock");
    vcc_ok_fall = 1'b0;
    step(1);
    chk(uvlo_active, 1, "R1 relock");
    step(1);
    chk(state_code, 0, "R8 uvlo clears latch");
    vcc_ok_fall = 1'b1;
    step(3);
    chk(uvlo_active, 1, "R1 fall only again");
    vcc_ok_rise = 1'b1;
    step(2);
    chk(state_code, 1, "R2 restart after uvlo");
    ramp_all("third");

    // Lockout in RUN
    vcc_ok_rise = 1'b0; vcc_ok_fall = 1'b0;
    step(2);
    chk(state_code, 0, "R2 uvlo in run");
    chk(drv_en, 0, "R4 drv off reset");
    chk(ss_code, 0, "R2 code off");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule